// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Register

This block carries one data word from a writing port to a reading port that runs on an unrelated clock, outside the FIFO path. One instance serves one direction, so a bidirectional port pair uses two of them. The writer stores a word by making a write access with its mailbox select high. The stored word then stays in place until the reader takes it with a read access, also with its mailbox select high.

A single active-low "mail vacant" flag shows whether the mailbox is free. A store drives it low and a read drives it high again. Each clock domain sees its own registered copy of the flag. The writer's copy drops on the storing edge. The reader's copy rises on the reading edge. Each copy follows the other side's action through a two-stage toggle synchronizer.

While the writer's copy is low, further stores are locked out, so the stored word cannot change while the reader may be sampling it. For this reason the data path needs no synchronizer. Resetting the FIFO that runs in the same direction clears the handshake and makes the mailbox vacant on both sides. The block also contains the reader's output selector, which puts either the mailbox word or the FIFO output-register word on the reader's bus.

Top module: `mailbox_bypass`

## Requirements
- R1: After reset is applied in both domains, `wr_mbox_vacant` and `rd_mbox_vacant` are both 1. With `rd_oe`=1 and `rd_mb_sel`=0, `rd_bus` equals `fifo_q`.
- R2: A writer edge with `wr_access`=1, `wr_mb_sel`=1 and `wr_mbox_vacant`=1 stores `wr_data` and drives `wr_mbox_vacant` to 0 after that edge.
- R3: A write access with `wr_mb_sel`=0 leaves the mailbox untouched, and both vacant flags stay 1.
- R4: While `wr_mbox_vacant` is 0, a write access with `wr_mb_sel`=1 is ignored. The stored word and both flags keep their values.
- R5: After a store, `rd_mbox_vacant` is 0 no later than the third reader edge.
- R6: A reader edge with `rd_access`=1, `rd_mb_sel`=1 and `rd_mbox_vacant`=0 drives `rd_mbox_vacant` to 1 after that edge.
- R7: After such a read, `wr_mbox_vacant` returns to 1 no later than the third writer edge.
- R8: A read with `rd_mb_sel`=0 does not clear pending mail. A read with `rd_mb_sel`=1 while `rd_mbox_vacant` is 1 does nothing, and the next store is still delivered correctly.
- R9: With `rd_oe`=1, `rd_bus` shows the mailbox word when `rd_mb_sel`=1 and `fifo_q` when `rd_mb_sel`=0. With `rd_oe`=0, `rd_bus` is all zeros.
- R10: A reset applied while mail is pending forces both vacant flags to 1.
- R11: The word presented to the reader equals the word that was stored, and it stays unchanged from the store until the reader's read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer clock |
| wr_rst | input | 1 | Synchronous active-high reset, writer domain |
| wr_mb_sel | input | 1 | Writer mailbox select |
| wr_access | input | 1 | Write access, already qualified by chip select and enable |
| wr_data | input | DATA_W | Word to store |
| wr_mbox_vacant | output | 1 | Mail flag seen by the writer (0 = mail waiting) |
| rd_clk | input | 1 | Reader clock |
| rd_rst | input | 1 | Synchronous active-high reset, reader domain |
| rd_mb_sel | input | 1 | Reader mailbox select, for both the read and the bus source |
| rd_access | input | 1 | Read access, already qualified by chip select and enable |
| rd_oe | input | 1 | Reader bus output enable |
| fifo_q | input | DATA_W | FIFO output-register word |
| rd_bus | output | DATA_W | Word driven toward the reader's bus |
| rd_mbox_vacant | output | 1 | Mail flag seen by the reader (0 = mail waiting) |

## Verification
The assertions assume that reset is held in both domains at the same time, for at least three edges of each clock. This puts the two toggles and every synchronizer stage back at the same value. The stimulus therefore always raises `wr_rst` and `rd_rst` together and holds them for six cycles of each clock. The assertions also assume that the inputs change only away from the rising edges. The bench drives every input one nanosecond after an edge or on a falling edge. In the random phase, the bench lets both clocks run several edges after each access so that both flag copies settle before it compares them with its model of the pending word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_W_DEF    = 36;
  localparam int unsigned MBX_SYNC_DEF = 2;

  typedef enum logic [1:0] {
    RD_SRC_OFF  = 2'd0,
    RD_SRC_FIFO = 2'd1,
    RD_SRC_MAIL = 2'd2
  } rd_src_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= {st[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/mbx_wr_port.sv
module mbx_wr_port #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mb_sel,
  input  logic              access,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_tog_async,
  output logic [DATA_W-1:0] mbox_q,
  output logic              wr_tog_q,
  output logic              vacant_n
);
  logic rd_tog_s;
  logic accept;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_rd_tog_sync (
    .clk (clk),
    .rst (rst),
    .d   (rd_tog_async),
    .q   (rd_tog_s)
  );

  // Low = mail waiting (toggles differ); the flag register is the toggle pair.
  assign vacant_n = ~(wr_tog_q ^ rd_tog_s);
  assign accept   = access & mb_sel & vacant_n;

  always_ff @(posedge clk) begin
    if (rst)         wr_tog_q <= 1'b0;
    else if (accept) wr_tog_q <= ~wr_tog_q;
  end

  // No reset on the data word: plain enable register.
  always_ff @(posedge clk) begin
    if (accept) mbox_q <= din;
  end

  AST_WR_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
    accept |=> !vacant_n) else $error("store did not lower the writer flag"); // R2

  AST_WR_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    (access && mb_sel && !vacant_n) |=> ($stable(mbox_q) && $stable(wr_tog_q)))
    else $error("store accepted while mail pending"); // R4
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mb_sel,
  input  logic              access,
  input  logic              oe,
  input  logic [DATA_W-1:0] fifo_q,
  input  logic [DATA_W-1:0] mbox_q,
  input  logic              wr_tog_async,
  output logic [DATA_W-1:0] bus,
  output logic              rd_tog_q,
  output logic              vacant_n
);
  logic    wr_tog_s;
  logic    accept;
  rd_src_e src;

  mbx_sync #(.STAGES(SYNC_STAGES)) u_wr_tog_sync (
    .clk (clk),
    .rst (rst),
    .d   (wr_tog_async),
    .q   (wr_tog_s)
  );

  assign vacant_n = ~(wr_tog_s ^ rd_tog_q);
  // A mailbox read only counts when the reader sees mail waiting.
  assign accept   = access & mb_sel & ~vacant_n;

  always_ff @(posedge clk) begin
    if (rst)         rd_tog_q <= 1'b0;
    else if (accept) rd_tog_q <= ~rd_tog_q;
  end

  always_comb begin
    if (!oe)         src = RD_SRC_OFF;
    else if (mb_sel) src = RD_SRC_MAIL;
    else             src = RD_SRC_FIFO;
  end

  always_comb begin
    unique case (src)
      RD_SRC_MAIL: bus = mbox_q;
      RD_SRC_FIFO: bus = fifo_q;
      default:     bus = '0;
    endcase
  end

  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    accept |=> vacant_n) else $error("read did not raise the reader flag"); // R6

  AST_RD_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
    (!vacant_n && !accept) |=> !vacant_n) else $error("mail vanished without a read"); // R8

  AST_MAIL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!vacant_n && !accept) |=> $stable(mbox_q)) else $error("mail word changed before read"); // R11
endmodule

// File: rtl/mailbox_bypass.sv
module mailbox_bypass
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_W_DEF,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_DEF
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_mb_sel,
  input  logic              wr_access,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_mbox_vacant,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_mb_sel,
  input  logic              rd_access,
  input  logic              rd_oe,
  input  logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] rd_bus,
  output logic              rd_mbox_vacant
);
  logic [DATA_W-1:0] mbox_q;
  logic              wr_tog;
  logic              rd_tog;

  mbx_wr_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .clk          (wr_clk),
    .rst          (wr_rst),
    .mb_sel       (wr_mb_sel),
    .access       (wr_access),
    .din          (wr_data),
    .rd_tog_async (rd_tog),
    .mbox_q       (mbox_q),
    .wr_tog_q     (wr_tog),
    .vacant_n     (wr_mbox_vacant)
  );

  mbx_rd_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .clk          (rd_clk),
    .rst          (rd_rst),
    .mb_sel       (rd_mb_sel),
    .access       (rd_access),
    .oe           (rd_oe),
    .fifo_q       (fifo_q),
    .mbox_q       (mbox_q),
    .wr_tog_async (wr_tog),
    .bus          (rd_bus),
    .rd_tog_q     (rd_tog),
    .vacant_n     (rd_mbox_vacant)
  );
endmodule

// File: tb/tb_mailbox_bypass.sv
`timescale 1ns/1ps
module tb_mailbox_bypass;
  localparam int W = 36;

  logic         wr_clk = 0, rd_clk = 0;
  logic         wr_rst = 1, rd_rst = 1;
  logic         wr_mb_sel = 0, wr_access = 0;
  logic [W-1:0] wr_data = '0;
  logic         rd_mb_sel = 0, rd_access = 0, rd_oe = 1;
  logic [W-1:0] fifo_q = '0;
  logic [W-1:0] rd_bus;
  logic         wr_mbox_vacant, rd_mbox_vacant;

  int n_chk = 0, n_fail = 0;
  logic         pend = 0;
  logic [W-1:0] word = '0;

  always #10 wr_clk = ~wr_clk;
  always #13 rd_clk = ~rd_clk;

  mailbox_bypass dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_mb_sel(wr_mb_sel), .wr_access(wr_access),
    .wr_data(wr_data), .wr_mbox_vacant(wr_mbox_vacant),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_mb_sel(rd_mb_sel), .rd_access(rd_access),
    .rd_oe(rd_oe), .fifo_q(fifo_q), .rd_bus(rd_bus), .rd_mbox_vacant(rd_mbox_vacant)
  );

  function automatic logic [W-1:0] rnd_word();
    return {$urandom() & 32'hF, $urandom()};
  endfunction

  function automatic logic [W-1:0] bus_expect(input logic oe, input logic sel,
                                              input logic [W-1:0] mail, input logic [W-1:0] fq);
    if (!oe) return '0;
    return sel ? mail : fq;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(posedge wr_clk);
    #1;
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(posedge rd_clk);
    #1;
  endtask

  task automatic settle();
    wait_w(4);
    wait_r(4);
  endtask

  task automatic wr_op(input logic sel, input logic [W-1:0] d);
    @(negedge wr_clk);
    wr_mb_sel = sel; wr_access = 1; wr_data = d;
    @(posedge wr_clk); #1;
    wr_access = 0; wr_mb_sel = 0;
  endtask

  // Read access; returns the bus value seen just before the clocking edge.
  task automatic rd_op(input logic sel, output logic [W-1:0] seen);
    @(negedge rd_clk);
    rd_mb_sel = sel; rd_access = 1;
    #1 seen = rd_bus;
    @(posedge rd_clk); #1;
    rd_access = 0; rd_mb_sel = 0;
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    wr_rst = 1; rd_rst = 1;
    wait_w(6); wait_r(6);
    @(negedge wr_clk); wr_rst = 0; rd_rst = 0;
    wait_w(2); wait_r(2);
    pend = 0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] seen;
    logic [W-1:0] a, b, c;
    void'($urandom(32'd1234));
    a = 36'hA_5A5A_0F0F; b = 36'h3_1234_5678; c = 36'hF_FFFF_0001;

    do_reset();
    check("R1 writer flag after reset", wr_mbox_vacant, 1);
    check("R1 reader flag after reset", rd_mbox_vacant, 1);
    @(negedge rd_clk); fifo_q = 36'h1_2345_6789; rd_oe = 1; rd_mb_sel = 0; #1;
    check("R1 bus shows fifo", rd_bus, 36'h1_2345_6789);

    wr_op(0, 36'h0_DEAD_BEEF);
    check("R3 fifo write leaves writer flag", wr_mbox_vacant, 1);
    wait_r(4);
    check("R3 fifo write leaves reader flag", rd_mbox_vacant, 1);

    wr_op(1, a);
    check("R2 store lowers writer flag", wr_mbox_vacant, 0);
    wait_r(3);
    check("R5 reader sees mail", rd_mbox_vacant, 0);
    @(negedge rd_clk); rd_mb_sel = 1; #1;
    check("R11 reader word", rd_bus, a);
    rd_mb_sel = 0;

    wr_op(1, b);
    check("R4 locked write keeps flag", wr_mbox_vacant, 0);
    wait_r(3);
    @(negedge rd_clk); rd_mb_sel = 1; #1;
    check("R4 locked write keeps word", rd_bus, a);
    rd_mb_sel = 0;

    rd_op(0, seen);
    check("R9 fifo read bus", seen, fifo_q);
    check("R8 fifo read keeps mail", rd_mbox_vacant, 0);

    rd_op(1, seen);
    check("R11 read returns stored word", seen, a);
    check("R6 read raises reader flag", rd_mbox_vacant, 1);
    wait_w(3);
    check("R7 writer flag returns", wr_mbox_vacant, 1);

    rd_op(1, seen);
    wait_r(3);
    check("R8 empty read no effect", rd_mbox_vacant, 1);
    wr_op(1, c);
    wait_r(3);
    check("R8 next store still seen", rd_mbox_vacant, 0);
    rd_op(1, seen);
    check("R8 next store word", seen, c);
    wait_w(3);

    @(negedge rd_clk); rd_oe = 0; rd_mb_sel = 1; #1;
    check("R9 bus off when disabled", rd_bus, '0);
    rd_oe = 1; rd_mb_sel = 0;

    wr_op(1, b);
    settle();
    check("R10 pending before reset", rd_mbox_vacant, 0);
    do_reset();
    check("R10 writer flag after reset", wr_mbox_vacant, 1);
    check("R10 reader flag after reset", rd_mbox_vacant, 1);

    for (int i = 0; i < 300; i++) begin
      int unsigned act;
      logic sel;
      logic [W-1:0] d;
      act = $urandom() % 3;
      sel = $urandom() % 4 != 0;
      d = rnd_word();
      @(negedge rd_clk); fifo_q = rnd_word(); rd_oe = ($urandom() % 8) != 0;
      if (act == 0) begin
        wr_op(sel, d);
        if (sel && !pend) begin
          check("R2 random store flag", wr_mbox_vacant, 0);
          pend = 1; word = d;
        end else begin
          check("R4 random ignored store flag", wr_mbox_vacant, !pend);
        end
      end else if (act == 1) begin
        rd_op(sel, seen);
        check("R9 random bus", seen, bus_expect(rd_oe, sel, word, fifo_q));
        if (sel && pend) begin
          check("R6 random read flag", rd_mbox_vacant, 1);
          pend = 0;
        end
      end
      settle();
      check("R7 random writer flag", wr_mbox_vacant, !pend);
      check("R5 random reader flag", rd_mbox_vacant, !pend);
      if (pend) begin
        @(negedge rd_clk); rd_oe = 1; rd_mb_sel = 1; #1;
        check("R11 random held word", rd_bus, word);
        rd_mb_sel = 0;
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule